// File: doc/BRIEF.md
# Interlace-Capable Raster Timing Generator

This block produces the line sync, frame sync, data-enable and field indication for one pixel clock domain. Horizontal and vertical counters walk the raster. Every timing value comes from run-time inputs, so one instance can serve many resolutions. These inputs are the line length and the first active pixel, the line-sync edges and their polarity, two vertical active windows, two frame-sync line ranges, the frame-sync polarity, an interlace flag and a horizontal shift for the second field's frame sync.

In progressive operation, only the first window and the first frame-sync range are used. In interlaced operation, the frame is split into two fields at the end line of the first window, and each field has its own active window and frame-sync range. The second field's frame-sync edges fall part-way along a line, typically half a line after the line-sync start.

All timing inputs are copied into a shadow set when a frame starts. Changes made while a frame is running therefore appear only from the next frame. An enable input halts the raster and restarts it from the first pixel of a frame.

Top module: `vtg_top`

## Requirements
- R1: While reset is asserted, all four outputs are 0. While the raster is stopped, `hsync` equals the captured `hs_low` bit, `vsync` equals the captured `vs_low` bit, and `de` and `field` are 0.
- R2: Within a line, the line sync is active for pixel counts `hs_start` <= h < `hs_stop`. The output level is active XOR `hs_low`, so `hs_low`=1 means active low.
- R3: `de` is 1 exactly when `act_start` <= h < `line_end` and the line lies inside the current field's active window. For the first window this means `win0_first` <= v < `win0_last`.
- R4: A line lasts `line_end` pixels. A progressive frame lasts `win0_last` lines, and an interlaced frame lasts `win1_last` lines.
- R5: The first field's frame sync is active from pixel (line `vs0_first`, count `hs_start`) up to, but not including, pixel (line `vs0_last`, count `hs_start`). The output level is active XOR `vs_low`.
- R6: `field` is 0 when progressive. When interlaced, `field` is 1 for lines v >= `win0_last` and 0 for earlier lines.
- R7: When interlaced, the second field's frame sync is active from pixel (line `vs1_first`, count `hs_start`+`vs_shift`) up to, but not including, pixel (line `vs1_last`, count `hs_start`+`vs_shift`).
- R8: When interlaced, in the second field `de` uses the window `win1_first` <= v < `win1_last`.
- R9: After `en` is sampled high while stopped, the outputs for pixel (0,0) appear two clock edges later, and the raster then advances one pixel per clock.
- R10: Timing inputs are captured only while stopped and at the frame wrap. A change made mid-frame takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Raster run/stop |
| line_end | input | 12 | Pixels per line; active video ends here |
| act_start | input | 12 | First active pixel of a line |
| hs_start | input | 12 | Line-sync leading pixel |
| hs_stop | input | 12 | Line-sync trailing pixel (exclusive) |
| hs_low | input | 1 | Line-sync polarity, 1 = active low |
| vs_shift | input | 12 | Horizontal shift of second-field frame sync |
| win0_first | input | 11 | First active line, field 0 |
| win0_last | input | 11 | End line of field 0 window; field-change line |
| win1_first | input | 11 | First active line, field 1 |
| win1_last | input | 11 | End line of field 1 window; interlaced frame length |
| vs0_first | input | 11 | Frame-sync start line, field 0 |
| vs0_last | input | 11 | Frame-sync end line, field 0 |
| vs1_first | input | 11 | Frame-sync start line, field 1 |
| vs1_last | input | 11 | Frame-sync end line, field 1 |
| vs_low | input | 1 | Frame-sync polarity, 1 = active low |
| interlace | input | 1 | 1 = two-field raster |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data enable |
| field | output | 1 | Field indicator |

## Verification
The first field's frame sync changes level on the same pixel where the line sync goes active, so two sync edges fall in one cycle. The bench provokes this coincidence in every frame by choosing small rasters. A per-pixel reference model, built from the window rules, judges both outputs on every cycle. A timing change made mid-frame also meets the frame wrap, where the old set still finishes the last pixel and the new set takes over at pixel (0,0). The bench drives such a change and compares the whole boundary pixel by pixel. It also measures the line, frame and field periods, and the latency from enable to the first line-sync edge.

// File: rtl/vtg_pkg.sv
// Shared widths and the captured timing set of the raster generator.
package vtg_pkg;
    parameter int unsigned TG_HW = 12;   // horizontal count width
    parameter int unsigned TG_VW = 11;   // vertical count width

    typedef struct packed {
        logic [TG_HW-1:0] h_end;
        logic [TG_HW-1:0] h_act;
        logic [TG_HW-1:0] hs_beg;
        logic [TG_HW-1:0] hs_end;
        logic [TG_HW-1:0] vs_off;
        logic             hs_pol;
        logic [TG_VW-1:0] w0_beg;
        logic [TG_VW-1:0] w0_end;
        logic [TG_VW-1:0] w1_beg;
        logic [TG_VW-1:0] w1_end;
        logic [TG_VW-1:0] vs0_beg;
        logic [TG_VW-1:0] vs0_end;
        logic [TG_VW-1:0] vs1_beg;
        logic [TG_VW-1:0] vs1_end;
        logic             vs_pol;
        logic             ilace;
    } vtg_cfg_t;
endpackage

// File: rtl/vtg_cfg_shadow.sv
// Holds the timing set used by the running frame.
// Assumes: load is high while stopped and on the frame-wrap cycle only.
module vtg_cfg_shadow
    import vtg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  vtg_cfg_t cfg_in,
    output vtg_cfg_t cfg_q
);
    // capture the live inputs when allowed, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (load)
            cfg_q <= cfg_in;
    end
endmodule

// File: rtl/vtg_raster_cnt.sv
// Pixel and line counters with a run flag.
// Assumes: totals come from the shadow set and change only at the wrap.
// The first enabled edge arms the run flag and leaves the counters at
// the origin, so pixel (0,0) is decoded on the edge after that.
module vtg_raster_cnt #(
    parameter int unsigned HW = 12,
    parameter int unsigned VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [HW-1:0] h_total,
    input  logic [VW-1:0] v_total,
    output logic          run,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vcnt,
    output logic          wrap
);
    localparam logic [HW-1:0] H_ONE = HW'(1);
    localparam logic [VW-1:0] V_ONE = VW'(1);

    logic [HW-1:0] h_last;
    logic [VW-1:0] v_last;
    logic          h_hit;
    logic          v_hit;

    // last valid positions of the raster
    always_comb begin
        h_last = h_total - H_ONE;
        v_last = v_total - V_ONE;
        h_hit  = (hcnt == h_last);
        v_hit  = (vcnt == v_last);
        wrap   = run && h_hit && v_hit;
    end

    // advance one pixel per clock while running
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            run  <= 1'b0;
            hcnt <= '0;
            vcnt <= '0;
        end else if (!run) begin
            run <= 1'b1;
        end else if (h_hit) begin
            hcnt <= '0;
            vcnt <= v_hit ? '0 : vcnt + V_ONE;
        end else begin
            hcnt <= hcnt + H_ONE;
        end
    end
endmodule

// File: rtl/vtg_window_decode.sv
// Combinational decode of counters against the captured timing set.
// Frame-sync windows compare (line, pixel) pairs in raster order, so an
// edge may fall part-way along a line. Assumes the shifted start is
// smaller than the line length.
module vtg_window_decode
    import vtg_pkg::*;
#(
    parameter int unsigned HW = 12,
    parameter int unsigned VW = 11
) (
    input  vtg_cfg_t      cfg,
    input  logic [HW-1:0] hcnt,
    input  logic [VW-1:0] vcnt,
    output logic          hs_act,
    output logic          vs_act,
    output logic          de_act,
    output logic          fld
);
    // true when (v,h) is at or after (lv,lh) in raster order
    function automatic logic reached(input logic [VW-1:0] v, input logic [HW-1:0] h,
                                     input logic [VW-1:0] lv, input logic [HW-1:0] lh);
        return (v > lv) || ((v == lv) && (h >= lh));
    endfunction

    logic [HW-1:0] hp1;
    logic          vs0_in;
    logic          vs1_in;
    logic          row0_in;
    logic          row1_in;
    logic          col_in;

    // window membership for both fields
    always_comb begin
        hp1     = cfg.hs_beg + cfg.vs_off;
        hs_act  = (hcnt >= cfg.hs_beg) && (hcnt < cfg.hs_end);
        vs0_in  = reached(vcnt, hcnt, cfg.vs0_beg, cfg.hs_beg) &&
                  !reached(vcnt, hcnt, cfg.vs0_end, cfg.hs_beg);
        vs1_in  = reached(vcnt, hcnt, cfg.vs1_beg, hp1) &&
                  !reached(vcnt, hcnt, cfg.vs1_end, hp1);
        vs_act  = vs0_in || (cfg.ilace && vs1_in);
        row0_in = (vcnt >= cfg.w0_beg) && (vcnt < cfg.w0_end);
        row1_in = cfg.ilace && (vcnt >= cfg.w1_beg) && (vcnt < cfg.w1_end);
        col_in  = (hcnt >= cfg.h_act) && (hcnt < cfg.h_end);
        de_act  = col_in && (row0_in || row1_in);
        fld     = cfg.ilace && (vcnt >= cfg.w0_end);
    end
endmodule

// File: rtl/vtg_top.sv
// Raster timing generator top: shadow capture, counters, decode and a
// registered output stage. Assumes all inputs are synchronous to clk.
module vtg_top
    import vtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [TG_HW-1:0]   line_end,
    input  logic [TG_HW-1:0]   act_start,
    input  logic [TG_HW-1:0]   hs_start,
    input  logic [TG_HW-1:0]   hs_stop,
    input  logic               hs_low,
    input  logic [TG_HW-1:0]   vs_shift,
    input  logic [TG_VW-1:0]   win0_first,
    input  logic [TG_VW-1:0]   win0_last,
    input  logic [TG_VW-1:0]   win1_first,
    input  logic [TG_VW-1:0]   win1_last,
    input  logic [TG_VW-1:0]   vs0_first,
    input  logic [TG_VW-1:0]   vs0_last,
    input  logic [TG_VW-1:0]   vs1_first,
    input  logic [TG_VW-1:0]   vs1_last,
    input  logic               vs_low,
    input  logic               interlace,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic               field
);
    localparam int unsigned HW = TG_HW;
    localparam int unsigned VW = TG_VW;

    vtg_cfg_t      cfg_in;
    vtg_cfg_t      sh_cfg;
    logic          run;
    logic          wrap;
    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic [VW-1:0] v_total;
    logic          hs_act, vs_act, de_act, fld;

    // gather the live timing inputs into one set
    always_comb begin
        cfg_in.h_end   = line_end;
        cfg_in.h_act   = act_start;
        cfg_in.hs_beg  = hs_start;
        cfg_in.hs_end  = hs_stop;
        cfg_in.vs_off  = vs_shift;
        cfg_in.hs_pol  = hs_low;
        cfg_in.w0_beg  = win0_first;
        cfg_in.w0_end  = win0_last;
        cfg_in.w1_beg  = win1_first;
        cfg_in.w1_end  = win1_last;
        cfg_in.vs0_beg = vs0_first;
        cfg_in.vs0_end = vs0_last;
        cfg_in.vs1_beg = vs1_first;
        cfg_in.vs1_end = vs1_last;
        cfg_in.vs_pol  = vs_low;
        cfg_in.ilace   = interlace;
    end

    // frame length follows the field layout of the captured set
    always_comb v_total = sh_cfg.ilace ? sh_cfg.w1_end : sh_cfg.w0_end;

    vtg_cfg_shadow u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (!run || wrap || !en),
        .cfg_in (cfg_in),
        .cfg_q  (sh_cfg)
    );

    vtg_raster_cnt #(.HW(HW), .VW(VW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .h_total (sh_cfg.h_end),
        .v_total (v_total),
        .run     (run),
        .hcnt    (hcnt),
        .vcnt    (vcnt),
        .wrap    (wrap)
    );

    vtg_window_decode #(.HW(HW), .VW(VW)) u_dec (
        .cfg    (sh_cfg),
        .hcnt   (hcnt),
        .vcnt   (vcnt),
        .hs_act (hs_act),
        .vs_act (vs_act),
        .de_act (de_act),
        .fld    (fld)
    );

    // register outputs; idle raster drives inactive sync levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync <= 1'b0;
            vsync <= 1'b0;
            de    <= 1'b0;
            field <= 1'b0;
        end else if (!run) begin
            hsync <= sh_cfg.hs_pol;
            vsync <= sh_cfg.vs_pol;
            de    <= 1'b0;
            field <= 1'b0;
        end else begin
            hsync <= hs_act ^ sh_cfg.hs_pol;
            vsync <= vs_act ^ sh_cfg.vs_pol;
            de    <= de_act;
            field <= fld;
        end
    end
endmodule

// File: rtl/vtg_chk.sv
// Temporal checks on the raster generator, bound into vtg_top.
module vtg_chk
    import vtg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             run,
    input logic             wrap,
    input logic [TG_HW-1:0] hcnt,
    input logic [TG_VW-1:0] vcnt,
    input logic [TG_HW-1:0] htot,
    input vtg_cfg_t         sh,
    input logic             de,
    input logic             field
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!de && !field));

    // R4
    hcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && htot != '0) |-> (hcnt < htot));

    // R9
    start_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (hcnt == '0 && vcnt == '0));

    // R10
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en && !wrap) |=> $stable(sh));

    // R3
    de_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> ($past(hcnt) >= $past(sh.h_act)));

    // R6
    field_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field |-> $past(sh.ilace));
endmodule

bind vtg_top vtg_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .run   (run),
    .wrap  (wrap),
    .hcnt  (hcnt),
    .vcnt  (vcnt),
    .htot  (sh_cfg.h_end),
    .sh    (sh_cfg),
    .de    (de),
    .field (field)
);

// File: tb/sim_vtg_top.sv
module sim_vtg_top;
    import vtg_pkg::*;

    typedef struct {
        logic hs;
        logic vs;
        logic de;
        logic fl;
        bit   f1;
        bit   idle;
    } exp_t;

    logic     clk = 1'b0;
    logic     rst_n = 1'b0;
    logic     en = 1'b0;
    vtg_cfg_t tc;
    logic     hsync, vsync, de, field;

    int    checks = 0;
    int    errors = 0;
    string phase = "R1 reset";
    exp_t  q[$];

    // model state
    int       mh = 0, mv = 0;
    bit       mrun = 0;
    vtg_cfg_t mc = '0;

    always #4 clk = ~clk;

    vtg_top u0 (
        .clk(clk), .rst_n(rst_n), .en(en),
        .line_end(tc.h_end), .act_start(tc.h_act), .hs_start(tc.hs_beg),
        .hs_stop(tc.hs_end), .hs_low(tc.hs_pol), .vs_shift(tc.vs_off),
        .win0_first(tc.w0_beg), .win0_last(tc.w0_end),
        .win1_first(tc.w1_beg), .win1_last(tc.w1_end),
        .vs0_first(tc.vs0_beg), .vs0_last(tc.vs0_end),
        .vs1_first(tc.vs1_beg), .vs1_last(tc.vs1_end),
        .vs_low(tc.vs_pol), .interlace(tc.ilace),
        .hsync(hsync), .vsync(vsync), .de(de), .field(field)
    );

    function automatic vtg_cfg_t prog_cfg();
        vtg_cfg_t c = '0;
        c.h_end = 20; c.h_act = 6; c.hs_beg = 1; c.hs_end = 4; c.hs_pol = 1'b1;
        c.w0_beg = 3; c.w0_end = 12; c.vs0_beg = 1; c.vs0_end = 2;
        c.vs_pol = 1'b1; c.ilace = 1'b0;
        return c;
    endfunction

    function automatic vtg_cfg_t ilace_cfg();
        vtg_cfg_t c = '0;
        c.h_end = 20; c.h_act = 6; c.hs_beg = 1; c.hs_end = 4; c.hs_pol = 1'b0;
        c.vs_off = 10;
        c.w0_beg = 2; c.w0_end = 8; c.w1_beg = 10; c.w1_end = 16;
        c.vs0_beg = 0; c.vs0_end = 1; c.vs1_beg = 8; c.vs1_end = 9;
        c.vs_pol = 1'b0; c.ilace = 1'b1;
        return c;
    endfunction

    // expected outputs for one pixel, from linear raster positions
    function automatic exp_t expect_px(int h, int v, vtg_cfg_t c);
        exp_t e;
        int ht = int'(c.h_end);
        int pos = v * ht + h;
        int hb = int'(c.hs_beg);
        int hb1 = hb + int'(c.vs_off);
        bit in0, in1, v0, v1;
        e.f1 = c.ilace && (v >= int'(c.w0_end));
        in0 = (v >= int'(c.w0_beg)) && (v < int'(c.w0_end));
        in1 = c.ilace && (v >= int'(c.w1_beg)) && (v < int'(c.w1_end));
        v0 = (pos >= int'(c.vs0_beg) * ht + hb) && (pos < int'(c.vs0_end) * ht + hb);
        v1 = (pos >= int'(c.vs1_beg) * ht + hb1) && (pos < int'(c.vs1_end) * ht + hb1);
        e.hs = ((h >= hb) && (h < int'(c.hs_end))) ^ c.hs_pol;
        e.vs = (v0 || (c.ilace && v1)) ^ c.vs_pol;
        e.de = (h >= int'(c.h_act)) && (h < ht) && (in0 || in1);
        e.fl = e.f1;
        e.idle = 0;
        return e;
    endfunction

    // driver side of the scoreboard: one expected item per edge
    always @(posedge clk) begin
        exp_t e;
        int vt;
        if (!rst_n) begin
            e = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
            mrun = 0; mh = 0; mv = 0; mc = '0;
        end else begin
            if (!mrun) e = '{mc.hs_pol, mc.vs_pol, 1'b0, 1'b0, 1'b0, 1'b1};
            else       e = expect_px(mh, mv, mc);
            if (!en) begin
                mrun = 0; mh = 0; mv = 0; mc = tc;
            end else if (!mrun) begin
                mrun = 1; mh = 0; mv = 0; mc = tc;
            end else begin
                vt = mc.ilace ? int'(mc.w1_end) : int'(mc.w0_end);
                if (mh == int'(mc.h_end) - 1) begin
                    mh = 0;
                    if (mv == vt - 1) begin mv = 0; mc = tc; end
                    else mv = mv + 1;
                end else mh = mh + 1;
            end
        end
        q.push_back(e);
    end

    task automatic cmp(input string tag, input string nm, input logic a, input logic x);
        checks++;
        if (a !== x) begin
            errors++;
            $display("FAIL %s (%s): %s got %b expected %b at %0t", tag, phase, nm, a, x, $time);
        end
    endtask

    // monitor side: compare each produced pixel with its expected item
    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            cmp(e.idle ? "R1" : "R2", "hsync", hsync, e.hs);
            cmp(e.idle ? "R1" : (e.f1 ? "R7" : "R5"), "vsync", vsync, e.vs);
            cmp(e.idle ? "R1" : (e.f1 ? "R8" : "R3"), "de", de, e.de);
            cmp(e.idle ? "R1" : "R6", "field", field, e.fl);
        end
    end

    // cycles between two active rising edges of a chosen output
    task automatic meas(input int sel, input logic pol, input int expct, input string tag);
        logic prev, cur;
        int n = 0;
        bit seen = 0;
        @(negedge clk);
        prev = ((sel == 0) ? hsync : (sel == 1) ? vsync : field) ^ pol;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            cur = ((sel == 0) ? hsync : (sel == 1) ? vsync : field) ^ pol;
            if (seen) n++;
            if (cur && !prev) begin
                if (seen) break;
                seen = 1; n = 0;
            end
            prev = cur;
        end
        checks++;
        if (n != expct) begin
            errors++;
            $display("FAIL %s: period got %0d expected %0d", tag, n, expct);
        end
    endtask

    // enable and count negedges until the line sync first goes active
    task automatic start_raster(input string tag);
        int n = 0;
        en = 1'b1;
        for (int i = 1; i < 100; i++) begin
            @(negedge clk);
            if ((hsync ^ tc.hs_pol) === 1'b1) begin n = i; break; end
        end
        checks++;
        if (n != int'(tc.hs_beg) + 2) begin
            errors++;
            $display("FAIL %s: first sync at %0d expected %0d", tag, n, int'(tc.hs_beg) + 2);
        end
    endtask

    task automatic idle_check(input string tag);
        checks++;
        if (hsync !== tc.hs_pol || vsync !== tc.vs_pol || de !== 1'b0 || field !== 1'b0) begin
            errors++;
            $display("FAIL %s: idle outputs got %b%b%b%b expected %b%b00", tag,
                     hsync, vsync, de, field, tc.hs_pol, tc.vs_pol);
        end
    endtask

    initial begin
        tc = prog_cfg();
        repeat (5) @(negedge clk);
        checks++;   // R1 reset state
        if ({hsync, vsync, de, field} !== 4'b0000) begin
            errors++;
            $display("FAIL R1: reset outputs got %b expected 0000", {hsync, vsync, de, field});
        end
        rst_n = 1'b1;
        phase = "R1 idle";
        repeat (6) @(negedge clk);
        idle_check("R1");

        phase = "R9 start";
        start_raster("R9");
        phase = "R2 R3 R5 progressive";
        meas(0, tc.hs_pol, 20, "R4 line");
        meas(1, tc.vs_pol, 240, "R4 frame");
        repeat (200) @(negedge clk);

        // mid-frame change: current frame must finish with the old set
        phase = "R10 shadow";
        tc = ilace_cfg();
        repeat (30) @(negedge clk);
        checks++;
        if (field !== 1'b0) begin
            errors++;
            $display("FAIL R10: field got %b expected 0 before wrap", field);
        end
        repeat (300) @(negedge clk);

        phase = "R6 R7 R8 interlaced";
        meas(2, 1'b0, 320, "R4 R6 interlaced frame");
        repeat (400) @(negedge clk);

        phase = "R1 stop";
        en = 1'b0;
        repeat (4) @(negedge clk);
        idle_check("R1");

        phase = "R9 restart";
        start_raster("R9");
        repeat (700) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule